// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It divides the system clock into a converter clock using a prescaler chosen by a 3-bit code. When the block is enabled and software raises the start bit, the sequencer waits for the next rising edge of the converter clock. It then issues a single-cycle sample-and-hold strobe on a falling half-edge of the converter clock. After that it runs ten bit trials, most significant bit first, against a comparator input. At the end it loads the result register, raises a completion flag and drops the start bit, all in the same system cycle.

The first conversion after the enable goes from low to high is longer: it lasts 25 converter clocks instead of 13, and the sample point moves from 1.5 to 13.5 clocks after the start. This gives the analog side time to settle. Clearing the enable aborts any conversion in progress, holds the prescaler in its reset phase and re-arms the long first conversion. The comparator is a plain digital input. The trial code driven on `dac_code` is what an external DAC would compare against.

The sequencer has five states. ST_IDLE waits for the start bit; it moves to ST_ACQUIRE if a converter rising edge falls in the same cycle, and to ST_ALIGN otherwise. ST_ALIGN moves to ST_ACQUIRE on the next converter rising edge. ST_ACQUIRE counts converter clocks and moves to ST_TRIAL on the sampling half-edge. ST_TRIAL settles one bit per converter rising edge and moves to ST_WRAP after bit 0. ST_WRAP returns to ST_IDLE on the next rising edge, which completes the conversion. Clearing the enable sends every state to ST_IDLE.

Top module: `sar_seq_top`

## Requirements
- R1: The converter clock period is 2, 2, 4, 8, 16, 32, 64, 128 system clocks for `prescale_sel` codes 0 to 7. While `en` is 0 the prescaler is held in reset and `adc_clk` stays low.
- R2: A conversion starts on the first rising edge of `adc_clk` that follows the cycle in which `busy` is seen high.
- R3: A normal conversion ends on the 13th rising edge of `adc_clk` after its start edge.
- R4: The first conversion after `en` rises ends on the 25th rising edge of `adc_clk` after its start edge.
- R5: `sample_strobe` is a one-cycle pulse on a falling edge of `adc_clk`. It comes 1.5 converter clocks after the start in a normal conversion and 13.5 in the first conversion, so completion always follows the strobe by 11.5 converter clocks.
- R6: The bit trials run from bit 9 down to bit 0, one per converter clock. A trial bit is kept when `cmp_in` is 1. With `cmp_in` high whenever `dac_code` is at or below an input level V, the result equals V.
- R7: In the cycle `done_flag` sets, `result` holds the new value and `busy` is 0. `result` changes at no other time. `done_flag` stays set until it is cleared.
- R8: A one-cycle pulse on `flag_clr` clears `done_flag` in the next cycle. A completion in the same cycle wins.
- R9: A pulse on `start_set` while `en` is 0 has no effect: `busy` stays 0 and no conversion completes.
- R10: Clearing `en` during a conversion aborts it: `busy` drops, no result is written, and the next conversion again takes the long first-conversion form.
- R11: After reset, `busy`, `done_flag`, `sample_strobe`, `result` and `adc_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| start_set | input | 1 | One-cycle pulse that sets the start bit |
| flag_clr | input | 1 | One-cycle pulse that clears the completion flag |
| prescale_sel | input | 3 | Prescaler code |
| cmp_in | input | 1 | Comparator decision, 1 keeps the trial bit |
| adc_clk | output | 1 | Converter clock |
| sample_strobe | output | 1 | Sample-and-hold pulse |
| dac_code | output | 10 | Current trial code |
| result | output | 10 | Last completed conversion |
| busy | output | 1 | Start bit; high from request to completion |
| done_flag | output | 1 | Completion flag |

## Verification
A wrong converter-clock count shows up as a wrong number of `adc_clk` rising edges between `busy` and `done_flag`. A first-conversion flag that is not re-armed does the same, and both are visible within one conversion. A misplaced sample point shifts `sample_strobe` by a whole or half converter clock relative to the edges. A bad trial order or keep rule corrupts `result`, and an exhaustive sweep of comparator thresholds exposes that on the first code affected.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ACQUIRE,
        ST_TRIAL,
        ST_WRAP
    } seq_state_t;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] sel,
    output logic              rise_tick,
    output logic              fall_tick,
    output logic              clk_level
);
    localparam int CNT_W = (2 ** PSEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   div_v;
    logic [CNT_W:0]   half_v;
    logic [CNT_W:0]   cnt_ext;

    always_comb begin
        if (sel == '0) div_v = (CNT_W+1)'(2);
        else           div_v = (CNT_W+1)'(1) << sel;
        half_v  = div_v >> 1;
        cnt_ext = {1'b0, cnt_q};
    end

    assign rise_tick = en && (cnt_ext >= div_v - 1'b1);
    assign fall_tick = en && (cnt_ext == half_v - 1'b1);
    assign clk_level = en && (cnt_ext < half_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!en)       cnt_q <= '0;
        else if (rise_tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             load,
    input  logic             decide,
    input  logic             capture,
    input  logic             cmp_in,
    output logic             last,
    output logic [RES_W-1:0] code,
    output logic [RES_W-1:0] result
);
    localparam int PTR_W = $clog2(RES_W);
    localparam logic [PTR_W-1:0] TOP_BIT = PTR_W'(RES_W - 1);

    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] result_q;
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            ptr_q    <= '0;
            result_q <= '0;
        end else if (abort) begin
            code_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (load) begin
                code_q        <= '0;
                code_q[TOP_BIT] <= 1'b1;
                ptr_q         <= TOP_BIT;
            end else if (decide) begin
                code_q[ptr_q] <= cmp_in;
                if (ptr_q != '0) begin
                    code_q[ptr_q - 1'b1] <= 1'b1;
                    ptr_q <= ptr_q - 1'b1;
                end
            end
            if (capture) result_q <= code_q;
        end
    end

    assign last   = (ptr_q == '0);
    assign code   = code_q;
    assign result = result_q;

    p_trial_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> (code_q[$past(ptr_q)] == $past(cmp_in)));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(result_q));

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int NORM_SAMPLE  = 1,
    parameter int FIRST_SAMPLE = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_set,
    input  logic flag_clr,
    input  logic rise_tick,
    input  logic fall_tick,
    input  logic trial_last,
    output logic trial_load,
    output logic trial_decide,
    output logic capture,
    output logic sample_strobe,
    output logic busy,
    output logic done_flag
);
    localparam int CYC_W = $clog2(FIRST_SAMPLE + 16);

    seq_state_t state_q, state_d;
    logic [CYC_W-1:0] cyc_q;
    logic [CYC_W-1:0] samp_idx;
    logic first_q, busy_q, flag_q, strobe_q;
    logic strobe_now, done_now;

    assign samp_idx = first_q ? CYC_W'(FIRST_SAMPLE) : CYC_W'(NORM_SAMPLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (busy_q) state_d = rise_tick ? ST_ACQUIRE : ST_ALIGN;
            ST_ALIGN:   if (rise_tick) state_d = ST_ACQUIRE;
            ST_ACQUIRE: if (fall_tick && cyc_q == samp_idx) state_d = ST_TRIAL;
            ST_TRIAL:   if (trial_decide && trial_last) state_d = ST_WRAP;
            ST_WRAP:    if (rise_tick) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        strobe_now   = en && state_q == ST_ACQUIRE && fall_tick && cyc_q == samp_idx;
        trial_decide = en && state_q == ST_TRIAL && rise_tick && cyc_q >= samp_idx + 1'b1;
        done_now     = en && state_q == ST_WRAP && rise_tick;
        trial_load   = strobe_now;
        capture      = done_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q    <= '0;
            first_q  <= 1'b1;
            busy_q   <= 1'b0;
            flag_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_now;
            if (done_now)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (!en) begin
                busy_q  <= 1'b0;
                first_q <= 1'b1;
                cyc_q   <= '0;
            end else begin
                if (done_now)       busy_q <= 1'b0;
                else if (start_set) busy_q <= 1'b1;
                if (done_now) first_q <= 1'b0;
                if (state_q == ST_IDLE || state_q == ST_ALIGN) cyc_q <= '0;
                else if (rise_tick)                            cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    assign sample_strobe = strobe_q;
    assign busy          = busy_q;
    assign done_flag     = flag_q;

    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_now |=> (flag_q && !busy_q));

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !done_now) |=> !flag_q);

    p_dis_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy_q);

    p_first_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (first_q && state_q == ST_IDLE));

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int RES_W        = 10,
    parameter int PSEL_W       = 3,
    parameter int NORM_SAMPLE  = 1,
    parameter int FIRST_SAMPLE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_set,
    input  logic              flag_clr,
    input  logic [PSEL_W-1:0] prescale_sel,
    input  logic              cmp_in,
    output logic              adc_clk,
    output logic              sample_strobe,
    output logic [RES_W-1:0]  dac_code,
    output logic [RES_W-1:0]  result,
    output logic              busy,
    output logic              done_flag
);
    logic rise_tick, fall_tick;
    logic trial_load, trial_decide, trial_last, capture;

    sar_prescaler #(.PSEL_W(PSEL_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sel       (prescale_sel),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .clk_level (adc_clk)
    );

    sar_sequencer #(.NORM_SAMPLE(NORM_SAMPLE), .FIRST_SAMPLE(FIRST_SAMPLE)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .start_set     (start_set),
        .flag_clr      (flag_clr),
        .rise_tick     (rise_tick),
        .fall_tick     (fall_tick),
        .trial_last    (trial_last),
        .trial_load    (trial_load),
        .trial_decide  (trial_decide),
        .capture       (capture),
        .sample_strobe (sample_strobe),
        .busy          (busy),
        .done_flag     (done_flag)
    );

    sar_trial #(.RES_W(RES_W)) u_trial (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (!en),
        .load    (trial_load),
        .decide  (trial_decide),
        .capture (capture),
        .cmp_in  (cmp_in),
        .last    (trial_last),
        .code    (dac_code),
        .result  (result)
    );

    p_strobe_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> (!adc_clk && $past(adc_clk)));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

endmodule

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       start_set = 1'b0;
    logic       flag_clr = 1'b0;
    logic [2:0] prescale_sel = 3'd0;
    logic       cmp_in;
    logic       adc_clk, sample_strobe, busy, done_flag;
    logic [9:0] dac_code, result;
    logic [9:0] vin_r = 10'd0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (dac_code <= vin_r);

    sar_seq_top i_sar_seq_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .start_set     (start_set),
        .flag_clr      (flag_clr),
        .prescale_sel  (prescale_sel),
        .cmp_in        (cmp_in),
        .adc_clk       (adc_clk),
        .sample_strobe (sample_strobe),
        .dac_code      (dac_code),
        .result        (result),
        .busy          (busy),
        .done_flag     (done_flag)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_conv(input int sel, input int vin, input bit first);
        int div;
        int rises = 0, s_rises = -1, s_cyc = 0, cyc = 0, nstrobe = 0;
        int last_rise = -1, period = -1;
        bit prev;
        bit timed_out = 0;
        div = (sel == 0) ? 2 : (1 << sel);
        @(negedge clk);
        prescale_sel = 3'(sel);
        vin_r = 10'(vin);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        chk(busy == 1'b1, "R2 busy set by start", int'(busy), 1);
        prev = adc_clk;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (adc_clk && !prev) begin
                rises++;
                if (last_rise >= 0) period = cyc - last_rise;
                last_rise = cyc;
            end
            prev = adc_clk;
            if (sample_strobe) begin
                nstrobe++;
                s_rises = rises;
                s_cyc = cyc;
            end
            if (done_flag) break;
            if (cyc > 8000) begin
                timed_out = 1;
                break;
            end
        end
        chk(!timed_out, "R3 conversion completes", int'(timed_out), 0);
        if (first)
            chk(rises == 26, "R4 first conversion edges", rises, 26);
        else
            chk(rises == 14, "R3 normal conversion edges", rises, 14);
        chk(s_rises == (first ? 14 : 2), "R2 R5 strobe position in edges", s_rises, first ? 14 : 2);
        chk(cyc - s_cyc == (23 * div) / 2, "R5 strobe to done cycles", cyc - s_cyc, (23 * div) / 2);
        chk(nstrobe == 1, "R5 single strobe", nstrobe, 1);
        chk(period == div, "R1 converter clock period", period, div);
        chk(result == 10'(vin), "R6 result value", int'(result), vin);
        chk(busy == 1'b0, "R7 busy clear at done", int'(busy), 0);
        @(negedge clk);
        chk(done_flag == 1'b1, "R7 flag holds", int'(done_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R8 flag cleared", int'(done_flag), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [9:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 0, "R11 busy after reset", int'(busy), 0);
        chk(done_flag == 0, "R11 flag after reset", int'(done_flag), 0);
        chk(sample_strobe == 0, "R11 strobe after reset", int'(sample_strobe), 0);
        chk(result == 0, "R11 result after reset", int'(result), 0);
        chk(adc_clk == 0, "R11 R1 clock idle while disabled", int'(adc_clk), 0);

        // R9: start while disabled
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (busy || done_flag) break;
        end
        chk(busy == 0, "R9 start ignored busy", int'(busy), 0);
        chk(done_flag == 0, "R9 start ignored flag", int'(done_flag), 0);

        en = 1'b1;
        repeat (2) @(negedge clk);
        run_conv(0, 10'h358, 1'b1);

        // R6 exhaustive threshold sweep at the fastest prescale
        for (int v = 0; v < 1024; v++) run_conv(0, v, 1'b0);

        // R1 all prescale codes
        for (int s = 1; s < 8; s++) begin
            run_conv(s, 0, 1'b0);
            run_conv(s, 1023, 1'b0);
            run_conv(s, (s * 137) % 1024, 1'b0);
        end

        // R10 abort and re-arm
        held = result;
        @(negedge clk);
        prescale_sel = 3'd2;
        vin_r = 10'd77;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        repeat (30) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R10 abort clears busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (60) @(negedge clk);
        chk(done_flag == 0, "R10 no completion after abort", int'(done_flag), 0);
        chk(result == held, "R10 result unchanged by abort", int'(result), int'(held));
        run_conv(2, 500, 1'b1);
        run_conv(2, 501, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule